// File: doc/BRIEF.md
# Level-Priority Bus Arbiter

This block is the central arbiter of a shared expansion bus with several masters. Each requester has its own request line and a four-bit arbitration level. While an arbitration cycle runs, the arbiter resolves every competing level onto one shared level bus. Each bit of that bus is the wired-AND of the drivers still in contention, and a driver withdraws once it sees a 0 on a bit where it drives a 1. The survivor is therefore the requester with the numerically lowest level. After a settle period whose length is a parameter, the arbiter latches the winner, raises a one-hot grant and shows the winning level until the tenure ends.

A tenure ends when the owner drops its request, or when another master pulls the shared active-low preempt line. A master signalling burst tenure on the active-low burst line keeps the bus under preempt. It must still give the bus up after a bounded number of transfers counted while preempt is held. A fairness rule keeps a master that has been served out of arbitration until every other pending requester has had a turn.

Top module: `lvl_arbiter`

## Requirements
- R1: While reset is high and in the cycle after it, `grant_o` and `arb_o` are 0, `gnt_o` is all zero and `bus_lvl_o` is all ones (4'hF).
- R2: With no request asserted and no tenure running, `grant_o` and `arb_o` stay 0 and `bus_lvl_o` stays at all ones.
- R3: When requests appear while idle, `arb_o` rises one cycle later and stays high for exactly `SETTLE_CYC` cycles. `grant_o` rises in the cycle after `arb_o` falls. `arb_o` and `grant_o` are never high together.
- R4: The granted requester is the competitor with the numerically lowest level, where requester i's level is `lvl_i[4*i+3:4*i]`. `gnt_o` has bit i set and no other bit, and `bus_lvl_o` shows that level for the whole tenure. During the settle period `bus_lvl_o` also shows the lowest competing level.
- R5: When two competitors share the lowest level, the one with the lower index wins.
- R6: While the owner keeps its request, preempt is high (inactive), and no bounded-burst release is due, `grant_o` stays 1 and `bus_lvl_o` stays unchanged.
- R7: When the owner's request is low at a clock edge, `grant_o` is 0 and `bus_lvl_o` is all ones from the next cycle.
- R8: When `preempt_n_i` is 0 while `burst_n_i` is 1 during a tenure, the grant is removed in the next cycle. This also applies when a burst ends while preempt is still held.
- R9: Competitors are the requesters not yet served in the current round. Only when every current requester has been served does the round restart with all of them competing. A lower level does not let a served master win again early.
- R10: While `burst_n_i` is 0, preempt does not end the tenure at once. Transfers (`xfer_i` high) are counted only while preempt is 0, and the grant is removed in the cycle after the `BURST_LIMIT`-th counted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_REQ | Request line per requester, active high |
| lvl_i | input | N_REQ*LVL_W | Arbitration level per requester, requester i in bits [LVL_W*i +: LVL_W] |
| preempt_n_i | input | 1 | Shared preempt line, active low |
| burst_n_i | input | 1 | Burst tenure indicator from the owner, active low |
| xfer_i | input | 1 | One transfer completed by the owner this cycle |
| arb_o | output | 1 | Arbitration (settle) period in progress |
| grant_o | output | 1 | A tenure is active |
| gnt_o | output | N_REQ | One-hot grant to the owning requester |
| bus_lvl_o | output | LVL_W | Resolved level on the shared level bus, all ones when idle |

## Verification
The bench sweeps every request mask against many distinct level patterns. It carries the served set from one arbitration to the next, so a resolver that returned anything but the minimum, or a fairness mask that cleared too early or never cleared, shows up as a wrong one-hot grant. Ties at the lowest level are driven on purpose, because a resolver that kept both survivors would grant two masters at once. The tenure ends are tested separately. Preempt outside a burst must drop the grant in one cycle. Transfers made without preempt must not use up the burst allowance, so an off-by-one counter releases one transfer early or late. Ending a burst while preempt is held must release at once; a design that ignored this would let the owner keep the bus.

// File: rtl/lvl_arb_pkg.sv
package lvl_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;

endpackage

// File: rtl/lvl_arb_resolve.sv
// Logical model of the open-drain level bus: bit by bit, from the MSB down,
// each still-contending requester drives its level bit; the line is the
// AND of all drivers, and a driver showing 1 against a 0 drops out.
module lvl_arb_resolve #(
  parameter int N_REQ = 16,
  parameter int LVL_W = 4
) (
  input  logic [N_REQ-1:0]       compete_i,
  input  logic [N_REQ*LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]       bus_o,
  output logic [N_REQ-1:0]       win_oh_o
);

  logic [LVL_W-1:0] lv [N_REQ];
  logic [N_REQ-1:0] alive;
  logic [LVL_W-1:0] line;

  for (genvar g = 0; g < N_REQ; g++) begin : g_split
    assign lv[g] = lvl_i[g*LVL_W +: LVL_W];
  end

  always_comb begin
    alive = compete_i;
    line  = '1;
    for (int b = LVL_W - 1; b >= 0; b--) begin
      for (int i = 0; i < N_REQ; i++) begin
        if (alive[i] && !lv[i][b]) line[b] = 1'b0;
      end
      for (int i = 0; i < N_REQ; i++) begin
        if (alive[i] && lv[i][b] && !line[b]) alive[i] = 1'b0;
      end
    end
  end

  assign bus_o    = line;
  // equal levels can leave several survivors: keep the lowest index
  assign win_oh_o = alive & (~alive + N_REQ'(1));

endmodule

// File: rtl/lvl_arb_burst_cnt.sv
// Counts owner transfers made under preempt during a burst tenure.
module lvl_arb_burst_cnt #(
  parameter int BURST_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic step_i,
  output logic last_o
);

  localparam int CW = $clog2(BURST_LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = step_i && (cnt_q == CW'(BURST_LIMIT - 1));

endmodule

// File: rtl/lvl_arbiter.sv
module lvl_arbiter
  import lvl_arb_pkg::*;
#(
  parameter int N_REQ       = 16,
  parameter int LVL_W       = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int BURST_LIMIT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_REQ-1:0]       req_i,
  input  logic [N_REQ*LVL_W-1:0] lvl_i,
  input  logic                   preempt_n_i,
  input  logic                   burst_n_i,
  input  logic                   xfer_i,
  output logic                   arb_o,
  output logic                   grant_o,
  output logic [N_REQ-1:0]       gnt_o,
  output logic [LVL_W-1:0]       bus_lvl_o
);

  localparam int SW = $clog2(SETTLE_CYC + 1);

  arb_state_e       state_q;
  logic [SW-1:0]    settle_q;
  logic [N_REQ-1:0] served_q;
  logic [N_REQ-1:0] gnt_q;
  logic [LVL_W-1:0] lvl_q;

  logic [N_REQ-1:0] fresh, compete, res_oh;
  logic             fresh_any, compete_any;
  logic [LVL_W-1:0] res_lvl;
  logic             owner_req, preempt, in_burst, burst_last, release_now;

  // fairness: served masters sit out until no unserved requester remains
  assign fresh       = req_i & ~served_q;
  assign fresh_any   = |fresh;
  assign compete     = fresh_any ? fresh : req_i;
  assign compete_any = |compete;

  lvl_arb_resolve #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_resolve (
    .compete_i (compete),
    .lvl_i     (lvl_i),
    .bus_o     (res_lvl),
    .win_oh_o  (res_oh)
  );

  assign owner_req = |(gnt_q & req_i);
  assign preempt   = !preempt_n_i;
  assign in_burst  = !burst_n_i;

  lvl_arb_burst_cnt #(.BURST_LIMIT(BURST_LIMIT)) u_burst (
    .clk     (clk),
    .rst     (rst),
    .clear_i (state_q != ST_OWN),
    .step_i  ((state_q == ST_OWN) && preempt && in_burst && xfer_i),
    .last_o  (burst_last)
  );

  assign release_now = (state_q == ST_OWN) &&
                       (!owner_req || (preempt && !in_burst) || burst_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      settle_q <= '0;
      served_q <= '0;
      gnt_q    <= '0;
      lvl_q    <= '1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (compete_any) begin
            state_q  <= ST_ARB;
            settle_q <= '0;
            lvl_q    <= res_lvl;
          end
        end
        ST_ARB: begin
          if (!compete_any) begin
            state_q <= ST_IDLE;
            lvl_q   <= '1;
          end else if (settle_q == SW'(SETTLE_CYC - 1)) begin
            state_q  <= ST_OWN;
            gnt_q    <= res_oh;
            lvl_q    <= res_lvl;
            served_q <= (fresh_any ? served_q : '0) | res_oh;
          end else begin
            settle_q <= settle_q + SW'(1);
            lvl_q    <= res_lvl;
          end
        end
        ST_OWN: begin
          if (release_now) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
            lvl_q   <= '1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          gnt_q   <= '0;
          lvl_q   <= '1;
        end
      endcase
    end
  end

  assign arb_o     = (state_q == ST_ARB);
  assign grant_o   = (state_q == ST_OWN);
  assign gnt_o     = gnt_q;
  assign bus_lvl_o = lvl_q;

endmodule

// File: rtl/lvl_arbiter_chk.sv
module lvl_arbiter_chk #(
  parameter int N_REQ       = 16,
  parameter int LVL_W       = 4,
  parameter int BURST_LIMIT = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_REQ-1:0]       req_i,
  input logic                   preempt_n_i,
  input logic                   burst_n_i,
  input logic                   xfer_i,
  input logic                   arb_o,
  input logic                   grant_o,
  input logic [N_REQ-1:0]       gnt_o,
  input logic [LVL_W-1:0]       bus_lvl_o
);

  localparam int CW = $clog2(BURST_LIMIT + 2);

  logic [CW-1:0] xf_cnt;

  always_ff @(posedge clk) begin
    if (rst || !grant_o) xf_cnt <= '0;
    else if (!preempt_n_i && !burst_n_i && xfer_i) xf_cnt <= xf_cnt + CW'(1);
  end

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!arb_o && !grant_o) |-> (bus_lvl_o == '1));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(arb_o && grant_o));

  // R3
  grant_after_arb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> $past(arb_o));

  // R4
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> ($countones(gnt_o) == 1));

  // R4
  no_stray_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !grant_o |-> (gnt_o == '0));

  // R6
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && $past(grant_o)) |-> $stable(bus_lvl_o));

  // R7
  owner_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && ((gnt_o & req_i) == '0)) |=> !grant_o);

  // R8
  preempt_release_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && !preempt_n_i && burst_n_i) |=> !grant_o);

  // R10
  burst_bound_chk: assert property (@(posedge clk) disable iff (rst)
    xf_cnt <= CW'(BURST_LIMIT));

endmodule

bind lvl_arbiter lvl_arbiter_chk #(
  .N_REQ(N_REQ), .LVL_W(LVL_W), .BURST_LIMIT(BURST_LIMIT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .preempt_n_i (preempt_n_i),
  .burst_n_i   (burst_n_i),
  .xfer_i      (xfer_i),
  .arb_o       (arb_o),
  .grant_o     (grant_o),
  .gnt_o       (gnt_o),
  .bus_lvl_o   (bus_lvl_o)
);

// File: tb/lvl_arbiter_tb.sv
`timescale 1ns/1ps
module lvl_arbiter_tb;

  localparam int N  = 4;
  localparam int W  = 4;
  localparam int ST = 3;
  localparam int BL = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic [N*W-1:0] lvl_i = '0;
  logic         preempt_n_i = 1'b1;
  logic         burst_n_i = 1'b1;
  logic         xfer_i = 1'b0;
  logic         arb_o, grant_o;
  logic [N-1:0] gnt_o;
  logic [W-1:0] bus_lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] served_m = '0;

  always #5 clk = ~clk;

  lvl_arbiter #(.N_REQ(N), .LVL_W(W), .SETTLE_CYC(ST), .BURST_LIMIT(BL)) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .lvl_i(lvl_i),
    .preempt_n_i(preempt_n_i), .burst_n_i(burst_n_i), .xfer_i(xfer_i),
    .arb_o(arb_o), .grant_o(grant_o), .gnt_o(gnt_o), .bus_lvl_o(bus_lvl_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_i = '0; preempt_n_i = 1'b1; burst_n_i = 1'b1; xfer_i = 1'b0;
    step(2);
    chk(!grant_o && !arb_o && gnt_o == '0, "R1 flags", {grant_o, arb_o, gnt_o}, 0);
    chk(bus_lvl_o == 4'hF, "R1 level", bus_lvl_o, 4'hF);
    rst = 1'b0;
    served_m = '0;
    step(1);
    chk(!grant_o && !arb_o && bus_lvl_o == 4'hF, "R1 after", {grant_o, arb_o, bus_lvl_o}, 4'hF);
  endtask

  // one full arbitration from idle, compared against the bench's own model
  task automatic trial(input logic [N-1:0] mask, input logic [N*W-1:0] lv, input string tag);
    logic [N-1:0] fresh, comp;
    int best, bi;
    fresh = mask & ~served_m;
    comp  = (fresh != '0) ? fresh : mask;
    best = 16; bi = 0;
    for (int i = 0; i < N; i++) begin
      if (comp[i] && int'(lv[i*W +: W]) < best) begin
        best = int'(lv[i*W +: W]);
        bi = i;
      end
    end
    lvl_i = lv; req_i = mask;
    step(1);
    chk(arb_o && !grant_o, "R3 arb start", {arb_o, grant_o}, 2);
    chk(bus_lvl_o == W'(best), "R4 settle level", bus_lvl_o, best);
    step(ST - 1);
    chk(arb_o && !grant_o, "R3 arb length", {arb_o, grant_o}, 2);
    step(1);
    chk(grant_o && !arb_o, "R3 grant", {arb_o, grant_o}, 1);
    chk(gnt_o == N'(1 << bi), tag, gnt_o, 1 << bi);
    chk(bus_lvl_o == W'(best), "R4 level", bus_lvl_o, best);
    served_m = ((fresh != '0) ? served_m : '0) | N'(1 << bi);
    req_i = '0;
    step(1);
    chk(!grant_o && bus_lvl_o == 4'hF, "R7 drop", {grant_o, bus_lvl_o}, 4'hF);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N*W-1:0] lv;
    @(negedge clk);
    do_reset();

    // R2 idle
    step(4);
    chk(!grant_o && !arb_o && bus_lvl_o == 4'hF, "R2 idle", {grant_o, arb_o, bus_lvl_o}, 4'hF);

    // R4 sweep with fairness carried (R9)
    for (int k = 0; k < 4; k++) begin
      for (int t = 0; t < 16; t++) begin
        for (int m = 1; m < 16; m++) begin
          for (int i = 0; i < N; i++) lv[i*W +: W] = W'((i * (2*k + 1) + t) % 16);
          trial(N'(m), lv, "R4 winner");
        end
      end
    end

    // R5 tie at the lowest level
    do_reset();
    lv = {4'd9, 4'd7, 4'd7, 4'd9};
    trial(4'b0110, lv, "R5 tie");

    // R9 served master sits out despite a lower level
    do_reset();
    lv = {4'd12, 4'd11, 4'd5, 4'd0};
    trial(4'b0011, lv, "R9 first");
    trial(4'b0011, lv, "R9 served skipped");
    trial(4'b0011, lv, "R9 round restart");

    // R6 hold, then R8 preempt outside a burst
    do_reset();
    lvl_i = {4'd1, 4'd1, 4'd1, 4'd3};
    req_i = 4'b0001;
    step(1 + ST);
    chk(grant_o, "R6 granted", grant_o, 1);
    xfer_i = 1'b1;
    step(5);
    xfer_i = 1'b0;
    chk(grant_o && bus_lvl_o == 4'd3, "R6 hold", {grant_o, bus_lvl_o}, 5'h13);
    preempt_n_i = 1'b0;
    step(1);
    chk(!grant_o, "R8 preempt", grant_o, 0);
    preempt_n_i = 1'b1;
    step(1 + ST);
    chk(grant_o, "R8 regrant", grant_o, 1);

    // R10 burst: transfers without preempt are not counted
    burst_n_i = 1'b0;
    xfer_i = 1'b1;
    step(3);
    preempt_n_i = 1'b0;
    step(BL - 1);
    chk(grant_o, "R10 before limit", grant_o, 1);
    step(1);
    chk(!grant_o, "R10 at limit", grant_o, 0);
    xfer_i = 1'b0;
    preempt_n_i = 1'b1;
    step(1 + ST);
    chk(grant_o, "R10 regrant", grant_o, 1);
    preempt_n_i = 1'b0;
    step(2);
    chk(grant_o, "R10 burst holds", grant_o, 1);
    burst_n_i = 1'b1;
    step(1);
    chk(!grant_o, "R8 burst end", grant_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule